// File: doc/BRIEF.md
# Thermal Trip Emergency Power-Down Latch

This block sits in the always-on power domain. It turns a processor overheat indication (active low) into an immediate system power-down. Once the platform is out of reset, a sampled overheat forces every active-low sleep-level drive low at once. The forcing path is a plain combinational gate fed by a synchronized copy of the pin and by a trip latch. It does not rely on any sleep sequencer stepping through its states, and it asks the processor for no acknowledgement.

The trip is remembered. The drives stay low after the overheat pin returns inactive, and they stay low until the downstream sleep sequencer reports that the soft-off state has been reached. At the moment of the trip the block also raises a sticky status bit. It sends a one-cycle request that starts the ordinary soft-off sequence in parallel, in the same way a forced power-button shutdown would. When no trip is active, the sequencer's own sleep-level requests pass straight through to the drives.

Top module: `thermtrip_guard`

## Requirements
- R1: After always-on reset (`aon_rst_n` low at a clock edge), `trip_status` and `softoff_req` are 0 and the trip latch is clear. `sleep_drive_n` then equals `seq_sleep_n`.
- R2: While `plat_rst_n` is low, a low `overheat_n` has no effect. The drives are not forced, `trip_status` stays 0 and `softoff_req` stays 0.
- R3: `overheat_n` passes through two clocked stages. If it is low at rising edge k and `plat_rst_n` is high, every bit of `sleep_drive_n` is 0 from just after edge k+1. The block waits for no handshake.
- R4: After the latch has set, every bit of `sleep_drive_n` stays 0 even when `overheat_n` returns high. This holds until a soft-off indication arrives.
- R5: An overheat pulse that lasts a single clock cycle and is sampled at one edge is enough to set the latch.
- R6: `softoff_req` is high for exactly one cycle, starting just after the edge at which the latch sets.
- R7: `trip_status` sets at the same edge as the latch and stays set until `status_clr` is 1 at an edge. If a new trip and the clear arrive at the same edge, the set wins.
- R8: `status_clr` has no effect on the trip latch or on `sleep_drive_n`.
- R9: `soft_off_reached` high at an edge while latched clears the latch, and the drives return to `seq_sleep_n` when no overheat is sampled. Without a latched trip, `soft_off_reached` has no effect.
- R10: Taking `plat_rst_n` low does not clear a latched trip. Only a soft-off indication or always-on reset clears it.
- R11: With no trip active, each bit of `sleep_drive_n` follows the matching bit of `seq_sleep_n`. Bit 0 is the lightest sleep level and bit 2 is soft-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| aon_rst_n | input | 1 | Always-on power-good reset, synchronous, active low |
| plat_rst_n | input | 1 | Platform reset level; overheat is ignored while low |
| overheat_n | input | 1 | Asynchronous processor overheat indication, active low |
| soft_off_reached | input | 1 | Sleep sequencer reports the soft-off state |
| status_clr | input | 1 | Write-1 strobe that clears the trip status bit |
| seq_sleep_n | input | 3 | Sleep-level drives requested by the normal sequencer, active low |
| sleep_drive_n | output | 3 | Sleep-level drives to the board, active low |
| trip_status | output | 1 | Sticky thermal trip status |
| softoff_req | output | 1 | One-cycle request to start the soft-off sequence |

## Verification
The hardest case to reach is a trip that has already cleared at the pin but must still hold the drives down. The stimulus holds overheat low for exactly one sampled cycle and then returns it high. It then applies a status clear and a platform reset pulse while the latch holds, so that only the soft-off indication is left to release it. A second hard corner is a soft-off indication that arrives while overheat is still low. The stimulus releases and re-trips in back-to-back cycles, and it also drives a status clear that coincides with a fresh trip.

// File: rtl/thermtrip_pkg.sv
// Package: shared defaults and state encoding for the thermal trip guard.
// Assumes: nothing beyond IEEE 1800-2017.
package thermtrip_pkg;
    localparam int unsigned DEF_LEVELS = 3;
    localparam int unsigned DEF_SYNC   = 2;

    typedef enum logic {
        TRIP_WATCH = 1'b0,
        TRIP_HELD  = 1'b1
    } trip_state_e;
endpackage

// File: rtl/thermtrip_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; reset value is the inactive level of the input.
module thermtrip_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizing flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/thermtrip_latch.sv
// Trip latch: sets on a qualified trip, releases on soft-off indication.
// Assumes: trip_now is already synchronized and gated by platform reset.
module thermtrip_latch
    import thermtrip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trip_now,
    input  logic        release_i,
    output trip_state_e state_o,
    output logic        set_pulse_o
);
    trip_state_e state_q, state_d;
    logic        pulse_q;

    // Next state: hold until release, otherwise capture a qualified trip.
    always_comb begin
        state_d = state_q;
        case (state_q)
            TRIP_WATCH: if (trip_now)  state_d = TRIP_HELD;
            TRIP_HELD:  if (release_i) state_d = TRIP_WATCH;
            default:                   state_d = TRIP_WATCH;
        endcase
    end

    // Register the latch and the one-cycle set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRIP_WATCH;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= (state_q == TRIP_WATCH) && trip_now;
        end
    end

    assign state_o     = state_q;
    assign set_pulse_o = pulse_q;
endmodule

// File: rtl/thermtrip_status.sv
// Sticky status bit: set by an event, cleared by a write-1 strobe; set wins.
// Assumes: set_i and clr_i are single-clock-domain levels.
module thermtrip_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);
    logic status_q;

    // Update the sticky bit with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     status_q <= 1'b0;
        else if (set_i) status_q <= 1'b1;
        else if (clr_i) status_q <= 1'b0;
    end

    assign status_o = status_q;
endmodule

// File: rtl/thermtrip_guard.sv
// Top: thermal trip emergency power-down guard in the always-on domain.
// Forces all sleep drives low straight from the synchronized trip or the
// latch; the normal sequencer only supplies the drives when no trip exists.
// Assumes: plat_rst_n and soft_off_reached are synchronous to clk.
module thermtrip_guard
    import thermtrip_pkg::*;
#(
    parameter int unsigned SLEEP_LEVELS = DEF_LEVELS,
    parameter int unsigned SYNC_STAGES  = DEF_SYNC
) (
    input  logic                    clk,
    input  logic                    aon_rst_n,
    input  logic                    plat_rst_n,
    input  logic                    overheat_n,
    input  logic                    soft_off_reached,
    input  logic                    status_clr,
    input  logic [SLEEP_LEVELS-1:0] seq_sleep_n,
    output logic [SLEEP_LEVELS-1:0] sleep_drive_n,
    output logic                    trip_status,
    output logic                    softoff_req
);
    localparam int unsigned LVL_W = SLEEP_LEVELS;

    logic        overheat_sync_n;
    logic        trip_now;
    logic        force_off;
    logic        trip_set;
    trip_state_e trip_state;

    thermtrip_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (aon_rst_n),
        .d_async (overheat_n),
        .q_sync  (overheat_sync_n)
    );

    // Qualify the synchronized overheat with the platform reset level.
    always_comb trip_now = plat_rst_n && !overheat_sync_n;

    thermtrip_latch u_latch (
        .clk         (clk),
        .rst_n       (aon_rst_n),
        .trip_now    (trip_now),
        .release_i   (soft_off_reached),
        .state_o     (trip_state),
        .set_pulse_o (trip_set)
    );

    thermtrip_status u_status (
        .clk      (clk),
        .rst_n    (aon_rst_n),
        .set_i    (trip_now && (trip_state == TRIP_WATCH)),
        .clr_i    (status_clr),
        .status_o (trip_status)
    );

    // Hard override: fresh trip or held latch, no sequencer in the path.
    always_comb force_off = trip_now || (trip_state == TRIP_HELD);

    for (genvar lv = 0; lv < LVL_W; lv++) begin : g_drive
        // Per-level gate: low when forced, else the sequencer's request.
        always_comb sleep_drive_n[lv] = seq_sleep_n[lv] && !force_off;
    end

    assign softoff_req = trip_set;
endmodule

// File: rtl/thermtrip_guard_chk.sv
// Checker bound to thermtrip_guard: temporal rules on latch and outputs.
// Assumes: bound to every instance of the top module.
module thermtrip_guard_chk #(
    parameter int unsigned LEVELS = 3
) (
    input logic              clk,
    input logic              aon_rst_n,
    input logic              plat_rst_n,
    input logic              soft_off_reached,
    input logic              softoff_req,
    input logic              trip_status,
    input logic              held,
    input logic [LEVELS-1:0] sleep_drive_n
);
    assert_ignore_in_reset_R2: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (!plat_rst_n && !held) |=> !softoff_req);

    assert_held_forces_off_R4: assert property (@(posedge clk) disable iff (!aon_rst_n)
        held |-> (sleep_drive_n == '0));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (held && !soft_off_reached) |=> held);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!aon_rst_n)
        softoff_req |=> !softoff_req);

    assert_pulse_with_latch_R6: assert property (@(posedge clk) disable iff (!aon_rst_n)
        softoff_req |-> held);

    assert_status_with_pulse_R7: assert property (@(posedge clk) disable iff (!aon_rst_n)
        softoff_req |-> trip_status);

    assert_release_R9: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (held && soft_off_reached) |=> !held);
endmodule

bind thermtrip_guard thermtrip_guard_chk #(.LEVELS(SLEEP_LEVELS)) u_chk (
    .clk              (clk),
    .aon_rst_n        (aon_rst_n),
    .plat_rst_n       (plat_rst_n),
    .soft_off_reached (soft_off_reached),
    .softoff_req      (softoff_req),
    .trip_status      (trip_status),
    .held             (trip_state == thermtrip_pkg::TRIP_HELD),
    .sleep_drive_n    (sleep_drive_n)
);

// File: tb/thermtrip_guard_test.sv
module thermtrip_guard_test;
    logic       clk = 1'b0;
    logic       aon_rst_n = 1'b0;
    logic       plat_rst_n = 1'b0;
    logic       overheat_n = 1'b1;
    logic       soft_off_reached = 1'b0;
    logic       status_clr = 1'b0;
    logic [2:0] seq_sleep_n = 3'b111;
    logic [2:0] sleep_drive_n;
    logic       trip_status;
    logic       softoff_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    bit m_pipe[$];
    bit m_held;
    bit m_status;
    bit m_req;
    string cur_req = "R1";

    always #5 clk = ~clk;

    thermtrip_guard uut (
        .clk              (clk),
        .aon_rst_n        (aon_rst_n),
        .plat_rst_n       (plat_rst_n),
        .overheat_n       (overheat_n),
        .soft_off_reached (soft_off_reached),
        .status_clr       (status_clr),
        .seq_sleep_n      (seq_sleep_n),
        .sleep_drive_n    (sleep_drive_n),
        .trip_status      (trip_status),
        .softoff_req      (softoff_req)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic model_reset();
        m_pipe.delete();
        m_pipe.push_back(1'b1);
        m_pipe.push_back(1'b1);
        m_held = 1'b0;
        m_status = 1'b0;
        m_req = 1'b0;
    endtask

    // advance the model over one rising edge with the inputs now applied
    task automatic model_edge();
        bit fresh;
        if (!aon_rst_n) begin
            model_reset();
        end else begin
            fresh = plat_rst_n && (m_pipe[0] == 1'b0);
            m_req = fresh && !m_held;
            if (fresh && !m_held) m_status = 1'b1;
            else if (status_clr)  m_status = 1'b0;
            if (m_held) m_held = !soft_off_reached;
            else        m_held = fresh;
            void'(m_pipe.pop_front());
            m_pipe.push_back(overheat_n);
        end
    endtask

    function automatic int exp_drive();
        bit fresh;
        fresh = plat_rst_n && (m_pipe[0] == 1'b0);
        return (fresh || m_held) ? 0 : int'(seq_sleep_n);
    endfunction

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({cur_req, " drive"}, int'(sleep_drive_n), exp_drive());
        chk({cur_req, " status"}, int'(trip_status), int'(m_status));
        chk({cur_req, " req"}, int'(softoff_req), int'(m_req));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        @(negedge clk);
        cur_req = "R1";
        steps(3);
        chk("R1 status after reset", int'(trip_status), 0);
        chk("R1 drives follow sequencer", int'(sleep_drive_n), 7);
        aon_rst_n = 1'b1;
        steps(2);

        // R2: overheat low while platform reset held low
        cur_req = "R2";
        overheat_n = 1'b0;
        steps(10);
        chk("R2 drives not forced", int'(sleep_drive_n), 7);
        chk("R2 status untouched", int'(trip_status), 0);
        overheat_n = 1'b1;
        steps(3);
        plat_rst_n = 1'b1;
        steps(3);

        // R11: sequencer pass-through with no trip
        cur_req = "R11";
        seq_sleep_n = 3'b101;
        step();
        chk("R11 pass-through", int'(sleep_drive_n), 5);
        seq_sleep_n = 3'b111;
        steps(2);

        // R9: soft-off with nothing latched has no effect
        cur_req = "R9";
        soft_off_reached = 1'b1;
        step();
        soft_off_reached = 1'b0;
        chk("R9 idle soft-off no effect", int'(sleep_drive_n), 7);

        // R5/R3: one-cycle glitch
        cur_req = "R5";
        overheat_n = 1'b0;
        step();
        overheat_n = 1'b1;
        cur_req = "R3";
        step();
        chk("R3 forced right after second stage", int'(sleep_drive_n), 0);
        chk("R3 no pulse yet", int'(softoff_req), 0);
        cur_req = "R6";
        step();
        chk("R6 request pulse", int'(softoff_req), 1);
        chk("R7 status set", int'(trip_status), 1);
        step();
        chk("R6 pulse only one cycle", int'(softoff_req), 0);
        cur_req = "R4";
        steps(10);
        chk("R4 held after pin clears", int'(sleep_drive_n), 0);
        chk("R5 glitch latched", int'(sleep_drive_n), 0);

        // R7/R8: clear status while held
        cur_req = "R8";
        status_clr = 1'b1;
        step();
        status_clr = 1'b0;
        chk("R7 status cleared", int'(trip_status), 0);
        chk("R8 drives still forced", int'(sleep_drive_n), 0);
        steps(2);

        // R10: platform reset pulse does not release
        cur_req = "R10";
        plat_rst_n = 1'b0;
        steps(4);
        chk("R10 latch survives platform reset", int'(sleep_drive_n), 0);
        plat_rst_n = 1'b1;
        steps(2);

        // R9: release on soft-off
        cur_req = "R9";
        soft_off_reached = 1'b1;
        step();
        soft_off_reached = 1'b0;
        chk("R9 released", int'(sleep_drive_n), 7);
        steps(3);

        // R7: clear coincident with fresh trip, set wins; soft-off while hot
        cur_req = "R7";
        status_clr = 1'b1;
        overheat_n = 1'b0;
        steps(3);
        chk("R7 set wins over clear", int'(trip_status), 1);
        step();
        chk("R7 clear after set", int'(trip_status), 0);
        status_clr = 1'b0;
        cur_req = "R9";
        soft_off_reached = 1'b1;
        steps(3);
        soft_off_reached = 1'b0;
        steps(3);
        overheat_n = 1'b1;
        steps(4);
        soft_off_reached = 1'b1;
        step();
        soft_off_reached = 1'b0;
        steps(3);
        chk("R9 final release", int'(sleep_drive_n), 7);

        // R1: always-on reset clears a held trip
        cur_req = "R1";
        overheat_n = 1'b0;
        steps(4);
        aon_rst_n = 1'b0;
        overheat_n = 1'b1;
        step();
        chk("R1 reset clears latch", int'(sleep_drive_n), 7);
        aon_rst_n = 1'b1;
        steps(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule